// File: doc/BRIEF.md
# Max Output Voltage Scan Sequencer

This block drives an external ADC across sixteen current-sink outputs and reports the highest output voltage it finds. The outputs are handled as eight pairs. Software starts the scan by writing the max-output code to the channel-select register. After that, the block uses one PWM dimming cycle for each pair. In that cycle it waits for the pair to be driven on, then waits a programmable blanking time, then converts each enabled channel of the pair one after the other.

A running maximum is kept while the scan runs. It is copied into the result register only when the eighth pair's slot closes. At that point a done flag is raised and the scan halts. Reading the result clears the flag and starts a fresh scan if the max-output code is still selected. Any write to the channel-select register also clears the flag and restarts the scan.

A system controller uses the reported peak to set the upstream supply just above the highest output voltage plus the sink dropout.

Top module: `maxv_scan_seq`

## Requirements
- R1: After reset, the channel-select register (offset 0) reads 0, the blanking register (offset 1) reads 4, the result register (offset 2) reads 0, the status register (offset 3, bit 0 = done) reads 0, and `adc_start_o` stays low.
- R2: Conversions are requested only while the channel-select register holds 0x06 and done is clear. Any other code produces no `adc_start_o` pulse.
- R3: Pair g covers channels 2g and 2g+1. Pair 0 is measured in the first dimming cycle after the scan starts, and each later cycle takes the next pair. Within a pair the lower channel is converted first, and `adc_ch_o` carries the channel index. The stepping is the same whether the pairs are on together or phase-shifted.
- R4: In its slot, a pair is converted only once its `grp_on_i` bit is high. The first `adc_start_o` comes B+2 clock edges after that bit is first driven high, where B is the blanking register value.
- R5: A channel whose `ch_en_i` bit is 0 is never converted. A pair with both channels disabled still uses up its dimming-cycle slot.
- R6: The running maximum starts at 0 on every scan start. The result register changes only when a scan completes, so a mid-scan read returns the previous result.
- R7: Done is set at the clock edge that samples the ninth `pwm_start_i` strobe after a scan starts. It is not set after the eighth strobe, and no conversion is requested while done is set.
- R8: Reading the result register while done is set clears done and restarts the scan from pair 0.
- R9: Any write to the channel-select register clears done and aborts any scan in progress. If the new code is 0x06, a new scan starts from pair 0. Any other code leaves the block idle.
- R10: If a pair's on-state drops before its blanking interval ends, that pair is not converted in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a result read has a side effect) |
| addr_i | input | 2 | Register offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle `rd_en_i` is high |
| pwm_start_i | input | 1 | One-cycle strobe at the start of each dimming cycle |
| grp_on_i | input | N_GRP | Per-pair on-state |
| ch_en_i | input | 2*N_GRP | Per-channel enable mask |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_ch_o | output | log2(2*N_GRP) | Channel to convert |
| adc_done_i | input | 1 | Conversion complete, data valid |
| adc_data_i | input | ADC_W | Conversion result |
| done_o | output | 1 | Scan complete flag |

## Verification
Register reads are combinational, so read data is sampled in the same cycle that `rd_en_i` is driven. Write and read side effects take hold at the next edge. The done flag and the result are due at the edge that samples the ninth strobe, so the bench reads status after the eighth cycle (expecting 0) and again after the ninth (expecting 1). The conversion request is due B+2 edges after the on-state is driven. The bench drives every input on the falling edge and counts falling edges until it sees the pulse, so it checks that exact count. The ADC model also answers only on falling edges, which keeps the start/done handshake clear of the active edge.

// File: rtl/maxv_scan_pkg.sv
package maxv_scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SYNC, S_WAITON, S_BLANK, S_CONV, S_HOLD
  } scan_st_e;

  localparam logic [7:0] SEL_MAXOUT = 8'h06;

  localparam logic [1:0] A_CHSEL  = 2'd0;
  localparam logic [1:0] A_BLANK  = 2'd1;
  localparam logic [1:0] A_RESULT = 2'd2;
  localparam logic [1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/maxv_scan_regs.sv
module maxv_scan_regs
  import maxv_scan_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADC_W     = 10,
  parameter int BLANK_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              finish_i,
  input  logic [ADC_W-1:0]  result_i,
  output logic [DATA_W-1:0] sel_o,
  output logic [DATA_W-1:0] blank_o,
  output logic              done_o,
  output logic              restart_o
);
  logic [DATA_W-1:0] sel_q, blank_q;
  logic              done_q;
  logic              sel_wr, res_rd;

  assign sel_wr    = wr_en_i && (addr_i == A_CHSEL);
  assign res_rd    = rd_en_i && (addr_i == A_RESULT);
  assign restart_o = sel_wr || (res_rd && done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      blank_q <= DATA_W'(BLANK_RST);
      done_q  <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= wdata_i;
      if (wr_en_i && (addr_i == A_BLANK)) blank_q <= wdata_i;
      // completion wins over a same-cycle clear
      if (finish_i)              done_q <= 1'b1;
      else if (sel_wr || res_rd) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_CHSEL:  rdata_o = sel_q;
        A_BLANK:  rdata_o = blank_q;
        A_RESULT: rdata_o = DATA_W'(result_i);
        default:  rdata_o = DATA_W'(done_q);
      endcase
    end
  end

  assign sel_o   = sel_q;
  assign blank_o = blank_q;
  assign done_o  = done_q;
endmodule

// File: rtl/maxv_scan_max.sv
module maxv_scan_max #(
  parameter int ADC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic [ADC_W-1:0] data_i,
  input  logic             commit_i,
  output logic [ADC_W-1:0] result_o
);
  logic [ADC_W-1:0] run_q, result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      result_q <= '0;
    end else begin
      if (clear_i)                          run_q <= '0;
      else if (sample_i && data_i > run_q)  run_q <= data_i;
      if (commit_i) result_q <= run_q;
    end
  end

  assign result_o = result_q;

  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(result_o));
endmodule

// File: rtl/maxv_scan_ctrl.sv
module maxv_scan_ctrl
  import maxv_scan_pkg::*;
#(
  parameter int N_GRP  = 8,
  parameter int DATA_W = 16,
  localparam int N_CH  = 2 * N_GRP,
  localparam int GRP_W = $clog2(N_GRP),
  localparam int CH_W  = GRP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] sel_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] blank_i,
  input  logic              pwm_start_i,
  input  logic [N_GRP-1:0]  grp_on_i,
  input  logic [N_CH-1:0]   ch_en_i,
  input  logic              adc_done_i,
  output logic              adc_start_o,
  output logic [CH_W-1:0]   adc_ch_o,
  output logic              clear_o,
  output logic              sample_o,
  output logic              finish_o
);
  scan_st_e          st_q;
  logic [GRP_W-1:0]  grp_q;
  logic              sub_q;
  logic              start_q;
  logic [DATA_W-1:0] cnt_q;
  logic [1:0]        pair_en;
  logic              last_grp, in_slot;

  assign pair_en  = ch_en_i[{grp_q, 1'b0} +: 2];
  assign last_grp = (grp_q == GRP_W'(N_GRP - 1));
  assign in_slot  = (st_q == S_WAITON) || (st_q == S_BLANK) ||
                    (st_q == S_CONV)   || (st_q == S_HOLD);

  assign clear_o  = (st_q == S_IDLE);
  assign sample_o = (st_q == S_CONV) && adc_done_i;
  assign finish_o = in_slot && pwm_start_i && last_grp && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      grp_q   <= '0;
      sub_q   <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart_i) begin
      st_q    <= S_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (sel_i == DATA_W'(SEL_MAXOUT) && !done_i) st_q <= S_SYNC;
      end else if (st_q == S_SYNC) begin
        if (pwm_start_i) begin
          grp_q <= '0;
          st_q  <= S_WAITON;
        end
      end else if (pwm_start_i) begin
        // slot boundary: every pair consumes exactly one dimming cycle
        if (last_grp) st_q <= S_IDLE;
        else begin
          grp_q <= grp_q + 1'b1;
          st_q  <= S_WAITON;
        end
      end else begin
        unique case (st_q)
          S_WAITON: begin
            if (pair_en == 2'b00) st_q <= S_HOLD;
            else if (grp_on_i[grp_q]) begin
              cnt_q <= blank_i;
              st_q  <= S_BLANK;
            end
          end
          S_BLANK: begin
            if (!grp_on_i[grp_q]) st_q <= S_HOLD;
            else if (cnt_q == '0) begin
              sub_q   <= !pair_en[0];
              start_q <= 1'b1;
              st_q    <= S_CONV;
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_CONV: begin
            if (adc_done_i) begin
              if (!sub_q && pair_en[1]) begin
                sub_q   <= 1'b1;
                start_q <= 1'b1;
              end else st_q <= S_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign adc_start_o = start_q;
  assign adc_ch_o    = {grp_q, sub_q};

  a_r2_start_needs_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (sel_i == DATA_W'(SEL_MAXOUT)));
  a_r5_start_enabled_ch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> ch_en_i[adc_ch_o]);
endmodule

// File: rtl/maxv_scan_seq.sv
module maxv_scan_seq #(
  parameter int N_GRP     = 8,
  parameter int ADC_W     = 10,
  parameter int DATA_W    = 16,
  parameter int BLANK_RST = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic                         rd_en_i,
  input  logic [1:0]                   addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic                         pwm_start_i,
  input  logic [N_GRP-1:0]             grp_on_i,
  input  logic [2*N_GRP-1:0]           ch_en_i,
  output logic                         adc_start_o,
  output logic [$clog2(2*N_GRP)-1:0]   adc_ch_o,
  input  logic                         adc_done_i,
  input  logic [ADC_W-1:0]             adc_data_i,
  output logic                         done_o
);
  logic              restart, finish, clear, sample;
  logic [DATA_W-1:0] sel, blank;
  logic [ADC_W-1:0]  result;

  maxv_scan_regs #(.DATA_W(DATA_W), .ADC_W(ADC_W), .BLANK_RST(BLANK_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .finish_i(finish), .result_i(result), .sel_o(sel), .blank_o(blank),
    .done_o, .restart_o(restart)
  );

  maxv_scan_ctrl #(.N_GRP(N_GRP), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .restart_i(restart), .sel_i(sel), .done_i(done_o),
    .blank_i(blank), .pwm_start_i, .grp_on_i, .ch_en_i, .adc_done_i,
    .adc_start_o, .adc_ch_o, .clear_o(clear), .sample_o(sample),
    .finish_o(finish)
  );

  maxv_scan_max #(.ADC_W(ADC_W)) u_max (
    .clk_i, .rst_ni, .clear_i(clear), .sample_i(sample), .data_i(adc_data_i),
    .commit_i(finish), .result_o(result)
  );

  a_r7_halt_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !adc_start_o);
  a_r7_done_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(pwm_start_i));
endmodule

// File: tb/maxv_scan_seq_test.sv
module maxv_scan_seq_test;
  localparam int CYC = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwm_start = 1'b0;
  logic [7:0]  grp_on = '0;
  logic [15:0] ch_en = '0;
  logic        adc_start;
  logic [3:0]  adc_ch;
  logic        adc_done = 1'b0;
  logic [9:0]  adc_data = '0;
  logic        done;

  int volt [16];
  int starts = 0, order_bad = 0, last_ch = -1;
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  maxv_scan_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_start_i(pwm_start),
    .grp_on_i(grp_on), .ch_en_i(ch_en), .adc_start_o(adc_start),
    .adc_ch_o(adc_ch), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .done_o(done)
  );

  // ADC model: three-cycle latency, answers on falling edges
  initial begin
    int lat = 0;
    int pend = 0;
    forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          adc_done = 1'b1;
          adc_data = 10'(volt[pend]);
        end
      end
      if (adc_start) begin
        starts++;
        if (int'(adc_ch) <= last_ch) order_bad++;
        last_ch = int'(adc_ch);
        pend = int'(adc_ch);
        lat = 3;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #2 v = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pwm_cycle(bit ph, int on_len);
    @(negedge clk);
    pwm_start = 1'b1; grp_on = '0;
    @(negedge clk);
    pwm_start = 1'b0;
    for (int t = 0; t < CYC; t++) begin
      for (int g = 0; g < 8; g++)
        grp_on[g] = ph ? (t >= g*6 && t < g*6 + on_len) : (t < on_len);
      @(negedge clk);
    end
    grp_on = '0;
  endtask

  task automatic clr_log();
    starts = 0; last_ch = -1; order_bad = 0;
  endtask

  typedef struct packed {
    logic [15:0] en;
    logic        ph;
    int          pk_ch;
    int          pk_val;
    int          exp_max;
    int          exp_starts;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'hFFFF, 1'b0,  5,  900,  900, 16},
    '{16'hFFFF, 1'b1, 14, 1000, 1000, 16},
    '{16'h7FFF, 1'b0, 15, 1023,  142, 15},
    '{16'h00F0, 1'b1,  0,  800,  121,  4},
    '{16'h0001, 1'b0,  0,    1,    1,  1},
    '{16'h0000, 1'b0,  3,  500,    0,  0},
    '{16'hAAAA, 1'b1,  9,  700,  700,  8}
  };

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    int v;
    int prev;
    int n;
    for (int c = 0; c < 16; c++) volt[c] = 100 + 3*c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 chsel", v, 0);
    rd(2'd1, v); chk("R1 blank", v, 4);
    rd(2'd2, v); chk("R1 result", v, 0);
    rd(2'd3, v); chk("R1 status", v, 0);
    chk("R1 no start", starts, 0);

    // R2 wrong code
    ch_en = 16'hFFFF;
    wr(2'd0, 5);
    repeat (3) pwm_cycle(1'b0, 30);
    chk("R2 no start other code", starts, 0);
    rd(2'd3, v); chk("R2 status", v, 0);

    // vector table
    prev = 0;
    foreach (VECS[i]) begin
      ch_en = VECS[i].en;
      for (int c = 0; c < 16; c++) volt[c] = (c == VECS[i].pk_ch) ? VECS[i].pk_val : 100 + 3*c;
      clr_log();
      wr(2'd0, 6);
      for (int k = 1; k <= 8; k++) begin
        pwm_cycle(VECS[i].ph, 30);
        if (k == 4) begin
          rd(2'd2, v); chk("R6 mid-scan result", v, prev);
        end
      end
      rd(2'd3, v); chk("R7 not done after 8", v, 0);
      pwm_cycle(VECS[i].ph, 30);
      rd(2'd3, v); chk("R7 done after 9", v, 1);
      chk("R5 start count", starts, VECS[i].exp_starts);
      chk("R3 ascending order", order_bad, 0);
      rd(2'd2, v); chk("R3 result max", v, VECS[i].exp_max);
      rd(2'd3, v); chk("R8 read clears done", v, 0);
      prev = VECS[i].exp_max;
    end

    // R7 halt, then R8 restart by result read
    ch_en = 16'hFFFF;
    wr(2'd0, 6);
    repeat (9) pwm_cycle(1'b0, 30);
    clr_log();
    repeat (2) pwm_cycle(1'b0, 30);
    chk("R7 no start while done", starts, 0);
    rd(2'd3, v); chk("R7 done held", v, 1);
    rd(2'd2, v); chk("R8 result", v, 700);
    clr_log();
    repeat (8) pwm_cycle(1'b0, 30);
    rd(2'd3, v); chk("R8 not done after 8", v, 0);
    pwm_cycle(1'b0, 30);
    rd(2'd3, v); chk("R8 done after rescan", v, 1);
    chk("R8 rescan starts", starts, 16);

    // R9 channel-select writes
    wr(2'd0, 0);
    rd(2'd3, v); chk("R9 write clears done", v, 0);
    clr_log();
    repeat (3) pwm_cycle(1'b0, 30);
    chk("R9 idle after other code", starts, 0);
    wr(2'd0, 6);
    repeat (4) pwm_cycle(1'b0, 30);
    wr(2'd0, 6);
    clr_log();
    repeat (8) pwm_cycle(1'b0, 30);
    rd(2'd3, v); chk("R9 restart from pair 0", v, 0);
    pwm_cycle(1'b0, 30);
    rd(2'd3, v); chk("R9 done after restart", v, 1);
    chk("R9 full rescan", starts, 16);

    // R4 blanking delay with B=2
    wr(2'd0, 0);
    wr(2'd1, 2);
    ch_en = 16'h0001;
    clr_log();
    wr(2'd0, 6);
    repeat (2) @(negedge clk);
    pwm_start = 1'b1;
    @(negedge clk);
    pwm_start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 waits for on", starts, 0);
    grp_on[0] = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!adc_start && n < 20);
    chk("R4 start delay", n, 4);
    grp_on = '0;
    repeat (6) @(negedge clk);
    wr(2'd0, 0);
    wr(2'd1, 4);

    // R10 on-time shorter than blanking
    ch_en = 16'hFFFF;
    clr_log();
    wr(2'd0, 6);
    repeat (9) pwm_cycle(1'b0, 3);
    chk("R10 no conversion", starts, 0);
    rd(2'd3, v); chk("R10 done", v, 1);
    rd(2'd2, v); chk("R10 R6 max cleared", v, 0);

    summary();
  end
endmodule